// File: doc/BRIEF.md
# In-Order Response Trigger Sequencer

This block watches a pipelined processor bus on which every request is answered by exactly one response. The responses come back in the same order as the requests. The block fires a trigger when one chosen transaction completes carrying one chosen data value. The default transaction is an I/O write to port `0x0080`, and the default data byte is `0xC7`.

The block keeps a count of transactions that have been issued but not yet answered. When the target write appears on the bus, the block records how many answers are still due ahead of it. It then lets that many responses pass. The next response after them belongs to the target, and the block compares its data. If that response matches, the trigger pulses for one cycle and the block waits in a finished state. If it does not match, the block drops back to idle. An arm input starts the search, so the trigger of another analyzer can enable this one.

States:
- `ST_IDLE` waits for arm.
- `ST_SEEK` is armed and watches for the target request.
- `ST_DEEP` is entered when too many transactions are pending ahead of the target. The block stays there until clear.
- `ST_RESP` lets earlier responses pass, then judges the target response.
- `ST_DONE` holds after a trigger.

Transitions:
- IDLE→SEEK when arm is high.
- SEEK→IDLE when arm drops.
- SEEK→RESP on the target request with at most `MAX_DEPTH` ahead.
- SEEK→DEEP on the target request with more than `MAX_DEPTH` ahead.
- RESP→DONE when the target response matches, with a trigger pulse.
- RESP→IDLE when the target response does not match.
- Any state→IDLE on clear.

Top module: `bus_resp_trigger`

## Requirements
- R1: After reset, `trig` and `done` are 0.
- R2: The outstanding count rises by one on each `ads` cycle and falls by one on each `rs` cycle. It holds when both occur in one cycle, and it stays within 0..`BUS_MAX`.
- R3: While not armed, no request or response causes a trigger.
- R4: The target request is an `ads` cycle with `addr` = 0x0080 and `cmd` = 4'h3 (I/O write). An `ads` cycle with any other command or address is only counted.
- R5: If N transactions are outstanding ahead of the target, counting a response in the same cycle as the target `ads` as already answered, the (N+1)th response after the target request is judged. No earlier response triggers.
- R6: The judged response matches only if `drdy` is 1, `defer` is 0 and `data` = 0xC7, all in the cycle where `rs` is 1.
- R7: A judged response that does not match returns the block to idle, and with arm held a later target can still trigger.
- R8: If more than `MAX_DEPTH` (4) transactions are ahead of the target, the block never triggers until `clr`.
- R9: `trig` is high for exactly one cycle, in the cycle after the matching response. `done` stays 1 from then on until a synchronous `clr`, and `clr` returns the block to idle.
- R10: Dropping arm while searching returns the block to idle, so a later target does not trigger.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr | input | 1 | Synchronous clear to idle |
| arm | input | 1 | Enables the search |
| ads | input | 1 | Request strobe |
| addr | input | ADDR_W | Request address |
| cmd | input | CMD_W | Request command |
| rs | input | 1 | Response strobe |
| defer | input | 1 | Response is deferred (carries no data) |
| drdy | input | 1 | Data-ready qualifier |
| data | input | DATA_W | Response data |
| trig | output | 1 | One-cycle trigger pulse |
| done | output | 1 | High after trigger until clear |

## Verification
The target request strobe and a response to an earlier transaction can arrive in the same cycle. That response must not be counted among those still due ahead of the target. The bench provokes this by asserting `rs` on the cycle of the target `ads`, on randomly chosen cases. It then expects the judgement one response earlier than it would otherwise. A response that arrives early with matching data would fire the trigger in the wrong cycle, so the bench checks the trigger cycle and counts every pulse.

// File: rtl/brt_pkg.sv
package brt_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SEEK,
        ST_DEEP,
        ST_RESP,
        ST_DONE
    } brt_state_e;
endpackage

// File: rtl/brt_outstanding.sv
module brt_outstanding #(
    parameter int BUS_MAX = 8,
    parameter int CNT_W   = $clog2(BUS_MAX + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ads,
    input  logic             rs,
    output logic [CNT_W-1:0] cnt
);
    localparam logic [CNT_W-1:0] TOP = CNT_W'(BUS_MAX);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else begin
            unique case ({ads, rs})
                2'b10:   if (cnt != TOP) cnt <= cnt + 1'b1;
                2'b01:   if (cnt != '0)  cnt <= cnt - 1'b1;
                default: cnt <= cnt;
            endcase
        end
    end
endmodule

// File: rtl/brt_req_match.sv
module brt_req_match #(
    parameter int               ADDR_W   = 16,
    parameter int               CMD_W    = 4,
    parameter logic [ADDR_W-1:0] TGT_ADDR = 16'h0080,
    parameter logic [CMD_W-1:0]  IOWR_CMD = 4'h3
) (
    input  logic              ads,
    input  logic [ADDR_W-1:0] addr,
    input  logic [CMD_W-1:0]  cmd,
    output logic              hit
);
    assign hit = ads && (addr == TGT_ADDR) && (cmd == IOWR_CMD);
endmodule

// File: rtl/brt_resp_match.sv
module brt_resp_match #(
    parameter int                DATA_W   = 8,
    parameter logic [DATA_W-1:0] TGT_DATA = 8'hC7
) (
    input  logic              rs,
    input  logic              defer,
    input  logic              drdy,
    input  logic [DATA_W-1:0] data,
    output logic              good
);
    assign good = rs && !defer && drdy && (data == TGT_DATA);
endmodule

// File: rtl/bus_resp_trigger.sv
module bus_resp_trigger
    import brt_pkg::*;
#(
    parameter int                ADDR_W    = 16,
    parameter int                CMD_W     = 4,
    parameter int                DATA_W    = 8,
    parameter int                BUS_MAX   = 8,
    parameter int                MAX_DEPTH = 4,
    parameter logic [ADDR_W-1:0] TGT_ADDR  = 16'h0080,
    parameter logic [CMD_W-1:0]  IOWR_CMD  = 4'h3,
    parameter logic [DATA_W-1:0] TGT_DATA  = 8'hC7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              arm,
    input  logic              ads,
    input  logic [ADDR_W-1:0] addr,
    input  logic [CMD_W-1:0]  cmd,
    input  logic              rs,
    input  logic              defer,
    input  logic              drdy,
    input  logic [DATA_W-1:0] data,
    output logic              trig,
    output logic              done
);
    localparam int CNT_W = $clog2(BUS_MAX + 1);
    localparam logic [CNT_W-1:0] DEPTH_LIM = CNT_W'(MAX_DEPTH);

    brt_state_e       state, nxt;
    logic [CNT_W-1:0] cnt, ahead, skip, skip_nxt;
    logic             req_hit, resp_good, fire;

    brt_outstanding #(.BUS_MAX(BUS_MAX), .CNT_W(CNT_W)) u_outstanding (
        .clk(clk), .rst_n(rst_n), .ads(ads), .rs(rs), .cnt(cnt)
    );

    brt_req_match #(
        .ADDR_W(ADDR_W), .CMD_W(CMD_W), .TGT_ADDR(TGT_ADDR), .IOWR_CMD(IOWR_CMD)
    ) u_req_match (
        .ads(ads), .addr(addr), .cmd(cmd), .hit(req_hit)
    );

    brt_resp_match #(.DATA_W(DATA_W), .TGT_DATA(TGT_DATA)) u_resp_match (
        .rs(rs), .defer(defer), .drdy(drdy), .data(data), .good(resp_good)
    );

    // A response in the target's own cycle answers an older transaction.
    assign ahead = (rs && cnt != '0) ? cnt - 1'b1 : cnt;

    always_comb begin
        nxt      = state;
        skip_nxt = skip;
        fire     = 1'b0;
        unique case (state)
            ST_IDLE: if (arm) nxt = ST_SEEK;
            ST_SEEK: begin
                if (!arm) begin
                    nxt = ST_IDLE;
                end else if (req_hit) begin
                    if (ahead > DEPTH_LIM) begin
                        nxt = ST_DEEP;
                    end else begin
                        nxt      = ST_RESP;
                        skip_nxt = ahead;
                    end
                end
            end
            ST_DEEP: nxt = ST_DEEP;
            ST_RESP: begin
                if (rs) begin
                    if (skip != '0) begin
                        skip_nxt = skip - 1'b1;
                    end else if (resp_good) begin
                        nxt  = ST_DONE;
                        fire = 1'b1;
                    end else begin
                        nxt = ST_IDLE;
                    end
                end
            end
            ST_DONE: nxt = ST_DONE;
            default: nxt = ST_IDLE;
        endcase
        if (clr) begin
            nxt  = ST_IDLE;
            fire = 1'b0;
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            skip  <= '0;
        end else begin
            state <= nxt;
            skip  <= skip_nxt;
        end
    end

    // Outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            trig <= 1'b0;
            done <= 1'b0;
        end else begin
            trig <= fire;
            done <= (nxt == ST_DONE);
        end
    end
endmodule

// File: rtl/brt_checker.sv
module brt_checker
    import brt_pkg::*;
#(
    parameter int                CNT_W    = 4,
    parameter int                BUS_MAX  = 8,
    parameter int                DATA_W   = 8,
    parameter logic [DATA_W-1:0] TGT_DATA = 8'hC7
) (
    input logic              clk,
    input logic              rst_n,
    input logic              clr,
    input logic              ads,
    input logic              rs,
    input logic              defer,
    input logic              drdy,
    input logic [DATA_W-1:0] data,
    input logic              trig,
    input logic              done,
    input brt_state_e        state,
    input logic [CNT_W-1:0]  cnt
);
    p_cnt_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CNT_W'(BUS_MAX));
    p_cnt_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (ads && rs) |=> $stable(cnt));
    p_idle_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |=> !trig);
    p_match_data_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(trig) |-> $past(rs && drdy && !defer && data == TGT_DATA));
    p_deep_stuck_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DEEP && !clr) |=> (state == ST_DEEP));
    p_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        trig |=> !trig);
    p_done_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !clr) |=> done);
    p_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (!done && !trig));
endmodule

bind bus_resp_trigger brt_checker #(
    .CNT_W(CNT_W), .BUS_MAX(BUS_MAX), .DATA_W(DATA_W), .TGT_DATA(TGT_DATA)
) u_brt_checker (
    .clk(clk), .rst_n(rst_n), .clr(clr), .ads(ads), .rs(rs), .defer(defer),
    .drdy(drdy), .data(data), .trig(trig), .done(done), .state(state), .cnt(cnt)
);

// File: tb/bus_resp_trigger_bench.sv
module bus_resp_trigger_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        clr = 1'b0, arm = 1'b0, ads = 1'b0, rs = 1'b0;
    logic        defer = 1'b0, drdy = 1'b0;
    logic [15:0] addr = '0;
    logic [3:0]  cmd = '0;
    logic [7:0]  data = '0;
    logic        trig, done;
    int n_chk = 0, n_fail = 0, trig_seen = 0;

    always #5 clk = ~clk;

    bus_resp_trigger u_bus_resp_trigger (
        .clk(clk), .rst_n(rst_n), .clr(clr), .arm(arm), .ads(ads), .addr(addr),
        .cmd(cmd), .rs(rs), .defer(defer), .drdy(drdy), .data(data),
        .trig(trig), .done(done)
    );

    task automatic tick();
        @(posedge clk);
        #1;
        if (trig) trig_seen++;
    endtask

    task automatic check(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int expect_trig(bit armed, int ahead, bit gd, bit dr, bit df, bit stuck);
        return (armed && !stuck && ahead <= 4 && gd && dr && !df) ? 1 : 0;
    endfunction

    // nb transactions issued ahead of the target; optional response in target cycle
    task automatic run_case(string req, int nb, bit same, bit gd, bit dr, bit df,
                            bit armed, bit do_clr, bit stuck, bit other_first);
        int ahead, exp;
        trig_seen = 0;
        arm = armed;
        tick();
        if (other_first) begin
            // non-I/O-write to the target port: counted, not matched (R4)
            ads = 1; addr = 16'h0080; cmd = 4'h6; tick(); ads = 0;
            rs = 1; drdy = 1; data = 8'hC7; tick(); rs = 0; drdy = 0;
        end
        for (int i = 0; i < nb; i++) begin
            ads = 1; addr = 16'h0010; cmd = 4'h6; tick();
        end
        ads = 1; addr = 16'h0080; cmd = 4'h3;
        if (same && nb > 0) begin rs = 1; drdy = 1; data = 8'h00; end
        tick();
        ads = 0; rs = 0; drdy = 0;
        ahead = (same && nb > 0) ? nb - 1 : nb;
        for (int i = 0; i < ahead; i++) begin
            rs = 1; drdy = 1; data = 8'hC7; tick();
        end
        rs = 1; drdy = dr; defer = df; data = gd ? 8'hC7 : 8'h3C;
        tick();
        rs = 0; drdy = 0; defer = 0;
        exp = expect_trig(armed, ahead, gd, dr, df, stuck);
        check({req, " R5 R6 trigger cycle"}, int'(trig), exp);
        tick();
        check("R9 single pulse", int'(trig), 0);
        check("R9 done held", int'(done), exp);
        check({req, " R5 pulse count"}, trig_seen, exp);
        if (do_clr) begin
            arm = 0; clr = 1; tick(); clr = 0;
            check("R9 clear", int'(done), 0);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(posedge clk);
        #1;
        check("R1 trig reset", int'(trig), 0);
        check("R1 done reset", int'(done), 0);
        rst_n = 1'b1;
        tick();
        // directed corner cases
        run_case("R4 depth0", 0, 0, 1, 1, 0, 1, 1, 0, 1);
        run_case("R2 same-cycle", 3, 1, 1, 1, 0, 1, 1, 0, 0);
        run_case("R5 depth4", 4, 0, 1, 1, 0, 1, 1, 0, 0);
        run_case("R6 no drdy", 1, 0, 1, 0, 0, 1, 1, 0, 0);
        run_case("R6 deferred", 2, 0, 1, 1, 1, 1, 1, 0, 0);
        run_case("R3 unarmed", 1, 0, 1, 1, 0, 0, 1, 0, 0);
        // R7: mismatch falls back, arm held, then a later target fires
        run_case("R7 mismatch", 1, 0, 0, 1, 0, 1, 0, 0, 0);
        run_case("R7 retry", 2, 0, 1, 1, 0, 1, 1, 0, 0);
        // R8: too deep, then stuck for a later good target
        run_case("R8 deep", 5, 0, 1, 1, 0, 1, 0, 0, 0);
        run_case("R8 stuck", 0, 0, 1, 1, 0, 1, 1, 1, 0);
        // R10: arm dropped while searching
        arm = 1; tick(); tick();
        run_case("R10 disarm", 0, 0, 1, 1, 0, 0, 1, 0, 0);
        // constrained random
        for (int k = 0; k < 40; k++) begin
            int nb;
            bit same, gd, dr, df;
            nb   = int'($urandom_range(0, 7));
            same = 1'($urandom_range(0, 1));
            gd   = ($urandom_range(0, 3) != 0);
            dr   = ($urandom_range(0, 3) != 0);
            df   = ($urandom_range(0, 5) == 0);
            run_case("R2 R5 random", nb, same, gd, dr, df, 1, 1, 0, 1'($urandom_range(0, 1)));
        end
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule